// File: doc/BRIEF.md
# DMA Transfer Address Update Unit

This unit works out where one DMA channel reads and writes next as data moves through a two-level loop: an inner minor loop of transfer beats, repeated the number of times held in a major-loop count. For each beat the channel engine presents the current source and destination addresses, the signed per-beat offsets, the loop configuration and the two count fields. The unit returns, one clock later, the address and count values to write back into the channel descriptor.

On a beat that ends a minor loop, the unit counts the major loop down by one. It can also add a signed minor-loop offset to the source address, the destination address, both or neither, under two independent enables. When the last minor loop of the major loop ends, a separate last-address adjustment for each direction takes the place of the minor-loop offset. The count is reloaded from the beginning count, and a done flag pulses for one cycle. Bus transfers, descriptor access, descriptor chaining and channel arbitration belong to other blocks.

Top module: `dma_addr_update`

## Requirements
- R1: `outValid` is high in the cycle after each cycle in which `stepValid` is high, and low otherwise. While `rstN` is low, every output reads zero.
- R2: For every step, each address output equals the matching address input plus its 16-bit signed offset, sign-extended to 32 bits. The addition wraps modulo 2^32, and the result then takes any loop term from R5 or R7.
- R3: A step with `minorLast` low returns `citerOut` equal to `citerIn`, does not assert `majorDone`, and adds neither the minor-loop offset nor the last adjustments.
- R4: A step with `minorLast` high and `citerIn` greater than 1 returns `citerOut = citerIn - 1`.
- R5: A step with `minorLast` high and `citerIn` greater than 1 adds `mlOff`, a 20-bit signed value sign-extended to 32 bits, to the source address when `srcMlEn` is high and to the destination address when `dstMlEn` is high. The two enables act independently.
- R6: When a direction's minor-loop enable is low, `mlOff` has no effect on that direction's address output.
- R7: A step with `minorLast` high and `citerIn` equal to 0 or 1 ends the major loop. It adds `srcLastAdj` and `dstLastAdj` in place of `mlOff`, whatever the enables are.
- R8: At the end of the major loop, `citerOut` equals `biterIn` and `majorDone` is high for that one output cycle only.
- R9: `majorDone` is never high while `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| stepValid | input | 1 | One transfer beat is presented this cycle |
| minorLast | input | 1 | This beat completes the minor loop |
| srcAddrIn | input | 32 | Current source address |
| dstAddrIn | input | 32 | Current destination address |
| srcOff | input | 16 | Signed per-beat source offset |
| dstOff | input | 16 | Signed per-beat destination offset |
| mlOff | input | 20 | Signed minor-loop offset |
| srcMlEn | input | 1 | Apply the minor-loop offset to the source |
| dstMlEn | input | 1 | Apply the minor-loop offset to the destination |
| srcLastAdj | input | 32 | Source adjustment at the end of the major loop |
| dstLastAdj | input | 32 | Destination adjustment at the end of the major loop |
| citerIn | input | 16 | Current major-loop count |
| biterIn | input | 16 | Beginning major-loop count |
| srcAddrOut | output | 32 | Updated source address |
| dstAddrOut | output | 32 | Updated destination address |
| citerOut | output | 16 | Updated major-loop count |
| outValid | output | 1 | Outputs hold a fresh result |
| majorDone | output | 1 | This result ends the major loop |

## Verification
Every cycle, the assertions check the one-cycle valid timing and the pairing of done with valid. They also check each kind of count update (hold, decrement, reload) and, for each address lane, the plain beat, the ignored minor-loop offset and the last-address adjustment, each against the inputs from the cycle before. Some results can only come from the bench's sweeps, which compute them arithmetically. These are the exact sums when the minor-loop offset is applied, wrap-around at the top and bottom of the address space, the extreme positive and negative offset values, and the treatment of a zero count as the end of the major loop. Only the bench's chained run, which feeds outputs back as the next inputs across two full major loops, shows that steps compose correctly.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

  // Strobes from the control path to the address datapath.
  typedef struct packed {
    logic       advance;   // a beat is being processed
    logic       minorEnd;  // the beat closes a minor loop
    logic       majorEnd;  // the beat closes the major loop
    logic [1:0] mlApply;   // per lane: add minor-loop offset (0 = source, 1 = destination)
  } stepCtl_t;

  localparam int unsigned LANES = 2;
  localparam int unsigned LANE_SRC = 0;
  localparam int unsigned LANE_DST = 1;

endpackage

// File: rtl/dma_addr_ctrl.sv
module dma_addr_ctrl
  import dma_addr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepValid,
  input  logic             minorLast,
  input  logic             srcMlEn,
  input  logic             dstMlEn,
  input  logic [CNT_W-1:0] citerIn,
  input  logic [CNT_W-1:0] biterIn,
  output stepCtl_t         ctl,
  output logic [CNT_W-1:0] citerOut,
  output logic             outValid,
  output logic             majorDone
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             countExpires;
  logic [CNT_W-1:0] countNext;

  // A count of zero or one at minor-loop end means no further minor loops.
  assign countExpires = (citerIn <= CNT_ONE);

  always_comb begin
    ctl          = '0;
    ctl.advance  = stepValid;
    ctl.minorEnd = stepValid & minorLast;
    ctl.majorEnd = stepValid & minorLast & countExpires;
    ctl.mlApply  = {dstMlEn, srcMlEn} & {2{ctl.minorEnd & ~ctl.majorEnd}};
  end

  always_comb begin
    if (!ctl.minorEnd) begin
      countNext = citerIn;
    end else if (ctl.majorEnd) begin
      countNext = biterIn;
    end else begin
      countNext = citerIn - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      citerOut  <= '0;
      outValid  <= 1'b0;
      majorDone <= 1'b0;
    end else begin
      outValid  <= stepValid;
      majorDone <= ctl.majorEnd;
      if (stepValid) begin
        citerOut <= countNext;
      end
    end
  end

  // R1: result valid exactly one cycle after a step
  a_r1_valid_follows_step : assert property (@(posedge clk) disable iff (!rstN)
    stepValid |=> outValid);
  a_r1_no_spurious_valid : assert property (@(posedge clk) disable iff (!rstN)
    !stepValid |=> !outValid);

  // R3: non-final beat keeps the count and never signals done
  a_r3_hold_count : assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && !minorLast) |=> (citerOut == $past(citerIn)) && !majorDone);

  // R4: minor-loop end with count above one decrements
  a_r4_decrement : assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && minorLast && (citerIn > CNT_ONE))
      |=> (citerOut == $past(citerIn) - CNT_ONE) && !majorDone);

  // R8: done comes with a reload from the beginning count
  a_r8_reload_on_done : assert property (@(posedge clk) disable iff (!rstN)
    majorDone |-> (citerOut == $past(biterIn)));
  a_r8_done_single : assert property (@(posedge clk) disable iff (!rstN)
    (majorDone && !$past(stepValid && minorLast)) |-> 1'b0);

  // R9: done never appears without valid
  a_r9_done_implies_valid : assert property (@(posedge clk) disable iff (!rstN)
    majorDone |-> outValid);

endmodule

// File: rtl/dma_addr_datapath.sv
module dma_addr_datapath
  import dma_addr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned MLOFF_W = 20
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  stepCtl_t                      ctl,
  input  logic [LANES-1:0][ADDR_W-1:0]  addrIn,
  input  logic [LANES-1:0][OFF_W-1:0]   beatOff,
  input  logic [MLOFF_W-1:0]            mlOff,
  input  logic [LANES-1:0][ADDR_W-1:0]  lastAdj,
  output logic [LANES-1:0][ADDR_W-1:0]  addrOut
);

  localparam int unsigned OFF_PAD   = ADDR_W - OFF_W;
  localparam int unsigned MLOFF_PAD = ADDR_W - MLOFF_W;

  logic [ADDR_W-1:0] mlExt;

  assign mlExt = {{MLOFF_PAD{mlOff[MLOFF_W-1]}}, mlOff};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] offExt;
    logic [ADDR_W-1:0] beatSum;
    logic [ADDR_W-1:0] loopTerm;
    logic [ADDR_W-1:0] addrNext;

    assign offExt  = {{OFF_PAD{beatOff[l][OFF_W-1]}}, beatOff[l]};
    assign beatSum = addrIn[l] + offExt;

    // Only one loop term per step: last adjustment wins over minor offset.
    always_comb begin
      if (ctl.majorEnd) begin
        loopTerm = lastAdj[l];
      end else if (ctl.mlApply[l]) begin
        loopTerm = mlExt;
      end else begin
        loopTerm = '0;
      end
    end

    assign addrNext = beatSum + loopTerm;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrOut[l] <= '0;
      end else if (ctl.advance) begin
        addrOut[l] <= addrNext;
      end
    end

    // R2 and R3: a non-final beat only adds the per-beat offset
    a_r2_plain_beat : assert property (@(posedge clk) disable iff (!rstN)
      (ctl.advance && !ctl.minorEnd) |=> (addrOut[l] == $past(addrIn[l] + offExt)));

    // R6: disabled lane ignores the minor-loop offset
    a_r6_offset_ignored : assert property (@(posedge clk) disable iff (!rstN)
      (ctl.minorEnd && !ctl.majorEnd && !ctl.mlApply[l])
        |=> (addrOut[l] == $past(addrIn[l] + offExt)));

    // R7: major-loop end adds the last adjustment only
    a_r7_last_adjust : assert property (@(posedge clk) disable iff (!rstN)
      ctl.majorEnd |=> (addrOut[l] == $past(addrIn[l] + offExt + lastAdj[l])));

    // R1: outputs hold when no step is presented
    a_r1_hold_idle : assert property (@(posedge clk) disable iff (!rstN)
      !ctl.advance |=> $stable(addrOut[l]));
  end

  // R5: offset application is only requested at a non-final minor-loop end
  a_r5_apply_gated : assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mlApply != 2'b00) |-> (ctl.minorEnd && !ctl.majorEnd));

endmodule

// File: rtl/dma_addr_update.sv
module dma_addr_update
  import dma_addr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned MLOFF_W = 20,
  parameter int unsigned CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stepValid,
  input  logic               minorLast,
  input  logic [ADDR_W-1:0]  srcAddrIn,
  input  logic [ADDR_W-1:0]  dstAddrIn,
  input  logic [OFF_W-1:0]   srcOff,
  input  logic [OFF_W-1:0]   dstOff,
  input  logic [MLOFF_W-1:0] mlOff,
  input  logic               srcMlEn,
  input  logic               dstMlEn,
  input  logic [ADDR_W-1:0]  srcLastAdj,
  input  logic [ADDR_W-1:0]  dstLastAdj,
  input  logic [CNT_W-1:0]   citerIn,
  input  logic [CNT_W-1:0]   biterIn,
  output logic [ADDR_W-1:0]  srcAddrOut,
  output logic [ADDR_W-1:0]  dstAddrOut,
  output logic [CNT_W-1:0]   citerOut,
  output logic               outValid,
  output logic               majorDone
);

  stepCtl_t                      ctl;
  logic [LANES-1:0][ADDR_W-1:0]  addrInVec;
  logic [LANES-1:0][OFF_W-1:0]   offVec;
  logic [LANES-1:0][ADDR_W-1:0]  adjVec;
  logic [LANES-1:0][ADDR_W-1:0]  addrOutVec;

  assign addrInVec[LANE_SRC] = srcAddrIn;
  assign addrInVec[LANE_DST] = dstAddrIn;
  assign offVec[LANE_SRC]    = srcOff;
  assign offVec[LANE_DST]    = dstOff;
  assign adjVec[LANE_SRC]    = srcLastAdj;
  assign adjVec[LANE_DST]    = dstLastAdj;
  assign srcAddrOut          = addrOutVec[LANE_SRC];
  assign dstAddrOut          = addrOutVec[LANE_DST];

  dma_addr_ctrl #(
    .CNT_W (CNT_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .stepValid (stepValid),
    .minorLast (minorLast),
    .srcMlEn   (srcMlEn),
    .dstMlEn   (dstMlEn),
    .citerIn   (citerIn),
    .biterIn   (biterIn),
    .ctl       (ctl),
    .citerOut  (citerOut),
    .outValid  (outValid),
    .majorDone (majorDone)
  );

  dma_addr_datapath #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (OFF_W),
    .MLOFF_W (MLOFF_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .addrIn  (addrInVec),
    .beatOff (offVec),
    .mlOff   (mlOff),
    .lastAdj (adjVec),
    .addrOut (addrOutVec)
  );

endmodule

// File: tb/dma_addr_update_tb.sv
`timescale 1ns/1ps
module dma_addr_update_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepValid = 1'b0;
  logic        minorLast = 1'b0;
  logic [31:0] srcAddrIn = '0;
  logic [31:0] dstAddrIn = '0;
  logic [15:0] srcOff = '0;
  logic [15:0] dstOff = '0;
  logic [19:0] mlOff = '0;
  logic        srcMlEn = 1'b0;
  logic        dstMlEn = 1'b0;
  logic [31:0] srcLastAdj = '0;
  logic [31:0] dstLastAdj = '0;
  logic [15:0] citerIn = '0;
  logic [15:0] biterIn = '0;
  logic [31:0] srcAddrOut;
  logic [31:0] dstAddrOut;
  logic [15:0] citerOut;
  logic        outValid;
  logic        majorDone;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_addr_update dut_i (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .minorLast(minorLast),
    .srcAddrIn(srcAddrIn), .dstAddrIn(dstAddrIn), .srcOff(srcOff), .dstOff(dstOff),
    .mlOff(mlOff), .srcMlEn(srcMlEn), .dstMlEn(dstMlEn),
    .srcLastAdj(srcLastAdj), .dstLastAdj(dstLastAdj),
    .citerIn(citerIn), .biterIn(biterIn),
    .srcAddrOut(srcAddrOut), .dstAddrOut(dstAddrOut), .citerOut(citerOut),
    .outValid(outValid), .majorDone(majorDone)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelAddr(input logic [31:0] a, input logic [15:0] off,
      input bit en, input bit last, input logic [15:0] cit,
      input logic [19:0] mlo, input logic [31:0] adj);
    logic [31:0] r;
    r = a + {{16{off[15]}}, off};
    if (last) begin
      if (cit <= 16'd1) r = r + adj;
      else if (en) r = r + {{12{mlo[19]}}, mlo};
    end
    return r;
  endfunction

  function automatic string addrTag(input bit last, input bit en, input logic [15:0] cit);
    if (!last) return "R2 R3";
    if (cit <= 16'd1) return "R7";
    return en ? "R5" : "R6";
  endfunction

  // Present one step, check the result one cycle later, then check idle.
  task automatic doStep(input logic [31:0] sa, input logic [31:0] da,
      input logic [15:0] so, input logic [15:0] dof, input logic [19:0] mlo,
      input bit se, input bit de, input bit last,
      input logic [15:0] cit, input logic [15:0] bit_,
      output logic [31:0] sOut, output logic [31:0] dOut, output logic [15:0] cOut);
    logic [31:0] expS, expD;
    logic [15:0] expC;
    bit expDone;
    @(negedge clk);
    stepValid = 1'b1; minorLast = last; srcAddrIn = sa; dstAddrIn = da;
    srcOff = so; dstOff = dof; mlOff = mlo; srcMlEn = se; dstMlEn = de;
    citerIn = cit; biterIn = bit_;
    expS = modelAddr(sa, so, se, last, cit, mlo, srcLastAdj);
    expD = modelAddr(da, dof, de, last, cit, mlo, dstLastAdj);
    expDone = last && (cit <= 16'd1);
    expC = !last ? cit : (expDone ? bit_ : cit - 16'd1);
    @(negedge clk);
    stepValid = 1'b0;
    check("R1 valid after step", {31'd0, outValid}, 32'd1);
    check(addrTag(last, se, cit), srcAddrOut, expS);
    check(addrTag(last, de, cit), dstAddrOut, expD);
    check(!last ? "R3 count" : (expDone ? "R8 reload" : "R4 decrement"),
          {16'd0, citerOut}, {16'd0, expC});
    check("R8 done flag", {31'd0, majorDone}, {31'd0, expDone});
    sOut = srcAddrOut; dOut = dstAddrOut; cOut = citerOut;
    @(negedge clk);
    check("R1 idle valid low", {31'd0, outValid}, 32'd0);
    check("R9 no done while idle", {31'd0, majorDone}, 32'd0);
    check("R1 hold src", srcAddrOut, expS);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] offTab [6];
    logic [19:0] mloTab [5];
    logic [15:0] citTab [5];
    logic [31:0] s, d;
    logic [15:0] c;
    offTab = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0004, 16'h8000, 16'h7FFF};
    mloTab = '{20'h00000, 20'hFFFFF, 20'h7FFFF, 20'h80000, 20'h00003};
    citTab = '{16'd0, 16'd1, 16'd2, 16'd5, 16'hFFFF};
    srcLastAdj = 32'h8000_0000;
    dstLastAdj = 32'hFFFF_FF9C;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset src", srcAddrOut, 32'd0);
    check("R1 reset dst", dstAddrOut, 32'd0);
    check("R1 reset count", {16'd0, citerOut}, 32'd0);
    check("R1 reset valid", {31'd0, outValid}, 32'd0);
    check("R9 reset done", {31'd0, majorDone}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 no valid without step", {31'd0, outValid}, 32'd0);

    // Near-exhaustive sweep across offsets, enables, loop end and counts.
    for (int i = 0; i < 6; i++) begin
      for (int en = 0; en < 4; en++) begin
        for (int lst = 0; lst < 2; lst++) begin
          for (int ci = 0; ci < 5; ci++) begin
            for (int mi = 0; mi < 5; mi++) begin
              doStep(32'hFFFF_FFF0 + 32'(i), 32'h0000_0008 * 32'(i),
                     offTab[i], offTab[5-i], mloTab[mi], en[0], en[1], lst[0],
                     citTab[ci], 16'd3 + 16'(ci), s, d, c);
            end
          end
        end
      end
    end

    // Back-to-back steps: valid stays high, done pulses once (R1, R8).
    @(negedge clk);
    stepValid = 1'b1; minorLast = 1'b1; citerIn = 16'd1; biterIn = 16'd9;
    srcAddrIn = 32'h100; dstAddrIn = 32'h200; srcOff = 16'd0; dstOff = 16'd0;
    @(negedge clk);
    citerIn = 16'd4;
    check("R8 done first", {31'd0, majorDone}, 32'd1);
    @(negedge clk);
    stepValid = 1'b0;
    check("R1 valid held", {31'd0, outValid}, 32'd1);
    check("R8 done one cycle", {31'd0, majorDone}, 32'd0);
    check("R4 decrement b2b", {16'd0, citerOut}, 32'd3);

    // Chained run: two major loops of 3 minor loops, 2 beats each (R2, R4, R5, R7, R8).
    s = 32'h2000_0000; d = 32'h3000_0000; c = 16'd3;
    for (int loopN = 0; loopN < 2; loopN++) begin
      for (int m = 0; m < 3; m++) begin
        for (int b = 0; b < 2; b++) begin
          doStep(s, d, 16'd4, 16'hFFFC, 20'hFFFF8, 1'b1, 1'b0, b == 1, c, 16'd3, s, d, c);
        end
      end
    end
    // Per major loop: src beat +4*6, minor offset -8 twice, last adj +0x80000000;
    // dst beat -4*6, last adj -100.
    check("R7 chained src", s, 32'h2000_0000 + 32'd2 * (32'd24 - 32'd16 + 32'h8000_0000));
    check("R7 chained dst", d, 32'h3000_0000 - 32'd2 * (32'd24 + 32'd100));
    check("R8 chained count", {16'd0, c}, 32'd3);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule